// File: doc/BRIEF.md
# Microprogrammed Control Unit

This block sequences a simple accumulator datapath by stepping through microinstructions held in an internal control store. A micro-address register selects one microinstruction per clock. Its operation part is split into four independently decoded 3-bit sub-fields: bus source, bus destination, ALU function and miscellaneous action. Each sub-field is expanded into a group of one-hot micro-command lines. Its sequencing part picks how the next micro-address is formed. There are four ways: an explicit next address, an opcode-mapped dispatch, a conditional branch on a selected status flag, or an end-of-routine return.

The control store is organised in four-word slots. Slot 0 is the common fetch routine and slot 1 is the interrupt routine. Each of the eight opcodes owns slot `2 + opcode`, so a dispatch lands on address `8 + 4*opcode`. Every instruction routine ends in a return. The return goes to the interrupt routine when an interrupt is pending at that moment, and to fetch otherwise. The interrupt routine always ends by jumping straight back to fetch. The datapath around the block is expected to apply the micro-commands during the cycle in which they are present on `ucmd`. The instruction opcode and the status flags are plain level inputs, and no handshake is involved.

Top module: `mc_ctrl`

## Requirements
- R1: While `rst_n` is low, `upc` is 0 and every bit of `ucmd` is 0.
- R2: `ucmd` is the decode of four sub-fields, each field f (source=0, destination=1, ALU=2, misc=3) owning bits `7*f .. 7*f+6`. A code k in 1..7 sets bit `7*f+k-1`, code 0 sets none, and the fields are decoded independently, so several fields may be active in one word.
- R3: One microinstruction executes per clock. On each rising edge, `ucmd` takes the commands of the word at the current `upc`, and `upc` takes that word's successor address on the same edge.
- R4: Fetch occupies addresses 0..3. Word 0 drives source PC (code 1) and destination MAR (code 1). Word 1 drives misc memory-read (code 1). Word 2 drives source MDR (code 2), destination IR (code 2) and misc PC-increment (code 3). Word 3 issues no command and dispatches.
- R5: A dispatch word sets `upc` to `8 + 4*opcode`, using the `opcode` value sampled at the edge that executes it.
- R6: A conditional-branch word moves to its explicit target when the selected flag is 1, and to `upc+1` otherwise. Flag bit 0 is negative (used by opcode 6) and bit 1 is zero (used by opcode 7). The taken path drives source IR-address (code 4) and destination PC (code 4), then returns. The not-taken path returns with no command. Other flag bits do not affect the choice.
- R7: A return word sends `upc` to 4 if `irq_pending` is 1 at its edge, and to 0 otherwise.
- R8: The interrupt routine runs 4→5→6→7→0 regardless of `irq_pending`. It drives, in order: source SP (6) with destination MAR and misc SP-decrement (6); source PC with destination MDR (6); misc memory-write (2); misc interrupt-acknowledge (5).
- R9: `irq_pending` has no effect on words that are not returns.
- R10: `opcode` has no effect on words that are not dispatches.
- R11: Each opcode routine issues its own sequence, with source/destination IR-address=4, ACC=3, TMP dest=5, ALU source=5, ALU add=1, sub=2, misc flag-load=4. NOP(0) returns at once. LOAD(1) runs IRA→MAR, read, MDR→ACC. STORE(2) runs IRA→MAR, ACC→MDR, write. ADD(3) and SUB(4) run IRA→MAR, read, MDR→TMP, then ALU→ACC with the ALU function and flag-load. JMP(5) runs IRA→PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 3 | Opcode of the instruction held in the datapath's IR |
| flags | input | 4 | Status flags: bit 0 negative, 1 zero, 2 carry, 3 overflow |
| irq_pending | input | 1 | Interrupt request level, sampled only by return words |
| ucmd | output | 28 | Registered one-hot micro-command groups, seven per sub-field |
| upc | output | 6 | Micro-address register (word executed on the next edge) |

## Verification
The bench traces every micro-address and command vector through fetch and all eight opcode routines. A design that decoded fields off by one, or merged fields, would show a wrong bit in `ucmd`. A design with an extra register stage would show commands a cycle late. Branches are driven with the selected flag alone set and with every other flag set. A design indexing the wrong flag would then take the wrong path. Interrupt handling is probed with the request raised in the middle of a routine (it must be ignored), raised at a return (it must divert to address 4), and held through the interrupt routine (it must still exit to fetch). A design that re-sampled the opcode after dispatch would jump into the wrong slot when the opcode changes mid-routine.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int OPC_W          = 3;
  localparam int FLAG_W         = 4;
  localparam int FSEL_W         = $clog2(FLAG_W);
  localparam int ADDR_W         = 6;
  localparam int FIELD_W        = 3;
  localparam int N_FIELDS       = 4;
  localparam int CMDS_PER_FIELD = (1 << FIELD_W) - 1;
  localparam int CMD_W          = N_FIELDS * CMDS_PER_FIELD;
  localparam int SLOT_LG        = 2;

  // slot numbering of the control store (each slot is 1<<SLOT_LG words)
  localparam int SL_FETCH = 0;
  localparam int SL_INT   = 1;
  localparam int SL_OP0   = 2;

  localparam logic [ADDR_W-1:0] FETCH_ENTRY = ADDR_W'(SL_FETCH << SLOT_LG);
  localparam logic [ADDR_W-1:0] INT_ENTRY   = ADDR_W'(SL_INT << SLOT_LG);
  localparam logic [ADDR_W-1:0] INT_LAST    = ADDR_W'((SL_INT << SLOT_LG) + (1 << SLOT_LG) - 1);

  // sub-field positions
  localparam int FLD_SRC  = 0;
  localparam int FLD_DST  = 1;
  localparam int FLD_ALU  = 2;
  localparam int FLD_MISC = 3;

  // source codes
  localparam int S_PC = 1, S_MDR = 2, S_ACC = 3, S_IRA = 4, S_ALU = 5, S_SP = 6;
  // destination codes
  localparam int D_MAR = 1, D_IR = 2, D_ACC = 3, D_PC = 4, D_TMP = 5, D_MDR = 6;
  // ALU codes
  localparam int A_ADD = 1, A_SUB = 2;
  // misc codes
  localparam int M_RD = 1, M_WR = 2, M_PCI = 3, M_FLG = 4, M_ACK = 5, M_SPD = 6;

  // flag selectors
  localparam int FL_NEG  = 0;
  localparam int FL_ZERO = 1;

  // opcodes
  localparam int OP_NOP = 0, OP_LOAD = 1, OP_STORE = 2, OP_ADD = 3;
  localparam int OP_SUB = 4, OP_JMP = 5, OP_BRN = 6, OP_BRZ = 7;

  typedef enum logic [1:0] {
    SEQ_NEXT     = 2'd0,
    SEQ_DISPATCH = 2'd1,
    SEQ_BRANCH   = 2'd2,
    SEQ_RETURN   = 2'd3
  } seq_mode_e;

  typedef struct packed {
    logic [ADDR_W-1:0]                 jump;
    logic [FSEL_W-1:0]                 fsel;
    seq_mode_e                         mode;
    logic [N_FIELDS-1:0][FIELD_W-1:0]  ops;
  } uword_t;

  function automatic int at(int slot, int off);
    return (slot << SLOT_LG) + off;
  endfunction

  function automatic uword_t mk(int src, int dst, int alu, int misc,
                                seq_mode_e mode, int fsel, int jump);
    uword_t w;
    w.ops[FLD_SRC]  = FIELD_W'(src);
    w.ops[FLD_DST]  = FIELD_W'(dst);
    w.ops[FLD_ALU]  = FIELD_W'(alu);
    w.ops[FLD_MISC] = FIELD_W'(misc);
    w.mode          = mode;
    w.fsel          = FSEL_W'(fsel);
    w.jump          = ADDR_W'(jump);
    return w;
  endfunction

endpackage

// File: rtl/mc_ctrl_store.sv
module mc_ctrl_store
  import mc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output uword_t            word
);

  localparam int SLOT_W = ADDR_W - SLOT_LG;

  function automatic uword_t rom_word(logic [ADDR_W-1:0] a);
    int slot;
    int off;
    uword_t w;
    slot = int'(a[ADDR_W-1:SLOT_LG]);
    off  = int'(a[SLOT_LG-1:0]);
    w    = mk(0, 0, 0, 0, SEQ_NEXT, 0, at(SL_FETCH, 0));
    case (slot)
      SL_FETCH: case (off)
        0: w = mk(S_PC,  D_MAR, 0, 0,     SEQ_NEXT, 0, at(SL_FETCH, 1));
        1: w = mk(0,     0,     0, M_RD,  SEQ_NEXT, 0, at(SL_FETCH, 2));
        2: w = mk(S_MDR, D_IR,  0, M_PCI, SEQ_NEXT, 0, at(SL_FETCH, 3));
        default: w = mk(0, 0, 0, 0, SEQ_DISPATCH, 0, 0);
      endcase
      SL_INT: case (off)
        0: w = mk(S_SP, D_MAR, 0, M_SPD, SEQ_NEXT, 0, at(SL_INT, 1));
        1: w = mk(S_PC, D_MDR, 0, 0,     SEQ_NEXT, 0, at(SL_INT, 2));
        2: w = mk(0,    0,     0, M_WR,  SEQ_NEXT, 0, at(SL_INT, 3));
        default: w = mk(0, 0, 0, M_ACK, SEQ_NEXT, 0, at(SL_FETCH, 0));
      endcase
      SL_OP0 + OP_NOP:
        if (off == 0) w = mk(0, 0, 0, 0, SEQ_RETURN, 0, 0);
      SL_OP0 + OP_LOAD: case (off)
        0: w = mk(S_IRA, D_MAR, 0, 0,    SEQ_NEXT,   0, at(SL_OP0 + OP_LOAD, 1));
        1: w = mk(0,     0,     0, M_RD, SEQ_NEXT,   0, at(SL_OP0 + OP_LOAD, 2));
        2: w = mk(S_MDR, D_ACC, 0, 0,    SEQ_RETURN, 0, 0);
        default: ;
      endcase
      SL_OP0 + OP_STORE: case (off)
        0: w = mk(S_IRA, D_MAR, 0, 0,    SEQ_NEXT,   0, at(SL_OP0 + OP_STORE, 1));
        1: w = mk(S_ACC, D_MDR, 0, 0,    SEQ_NEXT,   0, at(SL_OP0 + OP_STORE, 2));
        2: w = mk(0,     0,     0, M_WR, SEQ_RETURN, 0, 0);
        default: ;
      endcase
      SL_OP0 + OP_ADD, SL_OP0 + OP_SUB: case (off)
        0: w = mk(S_IRA, D_MAR, 0, 0,    SEQ_NEXT, 0, at(slot, 1));
        1: w = mk(0,     0,     0, M_RD, SEQ_NEXT, 0, at(slot, 2));
        2: w = mk(S_MDR, D_TMP, 0, 0,    SEQ_NEXT, 0, at(slot, 3));
        default: w = mk(S_ALU, D_ACC, (slot == SL_OP0 + OP_ADD) ? A_ADD : A_SUB,
                        M_FLG, SEQ_RETURN, 0, 0);
      endcase
      SL_OP0 + OP_JMP:
        if (off == 0) w = mk(S_IRA, D_PC, 0, 0, SEQ_RETURN, 0, 0);
      SL_OP0 + OP_BRN, SL_OP0 + OP_BRZ: case (off)
        0: w = mk(0, 0, 0, 0, SEQ_BRANCH,
                  (slot == SL_OP0 + OP_BRN) ? FL_NEG : FL_ZERO, at(slot, 2));
        1: w = mk(0,     0,    0, 0, SEQ_RETURN, 0, 0);
        2: w = mk(S_IRA, D_PC, 0, 0, SEQ_RETURN, 0, 0);
        default: ;
      endcase
      default: ;
    endcase
    return w;
  endfunction

  always_comb word = rom_word(addr);

endmodule

// File: rtl/mc_next_addr.sv
module mc_next_addr
  import mc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  seq_mode_e         mode,
  input  logic [FSEL_W-1:0] fsel,
  input  logic [ADDR_W-1:0] jump,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FLAG_W-1:0] flags,
  input  logic              irq,
  output logic [ADDR_W-1:0] uar
);

  logic [ADDR_W-1:0] nxt_addr;
  logic              cond;

  assign cond = flags[fsel];

  always_comb begin
    case (mode)
      SEQ_NEXT:     nxt_addr = jump;
      SEQ_DISPATCH: nxt_addr = (ADDR_W'(SL_OP0) + ADDR_W'(opcode)) << SLOT_LG;
      SEQ_BRANCH:   nxt_addr = cond ? jump : uar + ADDR_W'(1);
      default:      nxt_addr = irq ? INT_ENTRY : FETCH_ENTRY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uar <= FETCH_ENTRY;
    else        uar <= nxt_addr;
  end

  AST_RET_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SEQ_RETURN && !irq) |=> (uar == FETCH_ENTRY)); // R7
  AST_RET_TO_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SEQ_RETURN && irq) |=> (uar == INT_ENTRY)); // R7
  AST_BRANCH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SEQ_BRANCH && !flags[fsel]) |=> (uar == $past(uar) + ADDR_W'(1))); // R6
  AST_BRANCH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SEQ_BRANCH && flags[fsel]) |=> (uar == $past(jump))); // R6
  AST_DISPATCH_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SEQ_DISPATCH) |=> (uar[SLOT_LG-1:0] == '0)); // R5

endmodule

// File: rtl/mc_cmd_decode.sv
module mc_cmd_decode
  import mc_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_FIELDS-1:0][FIELD_W-1:0] ops,
  output logic [CMD_W-1:0]                 cmd
);

  logic [CMD_W-1:0] dec;

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
    for (genvar k = 1; k <= CMDS_PER_FIELD; k++) begin : g_cmd
      assign dec[f*CMDS_PER_FIELD + k - 1] = (ops[f] == FIELD_W'(k));
    end

    AST_FIELD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd[f*CMDS_PER_FIELD +: CMDS_PER_FIELD])); // R2
    AST_FIELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ops[f] == '0) |=> (cmd[f*CMDS_PER_FIELD +: CMDS_PER_FIELD] == '0)); // R2
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd <= '0;
    else        cmd <= dec;
  end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FLAG_W-1:0] flags,
  input  logic              irq_pending,
  output logic [CMD_W-1:0]  ucmd,
  output logic [ADDR_W-1:0] upc
);

  uword_t            word;
  logic [ADDR_W-1:0] uar;

  mc_ctrl_store u_store (
    .addr (uar),
    .word (word)
  );

  mc_next_addr u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (word.mode),
    .fsel   (word.fsel),
    .jump   (word.jump),
    .opcode (opcode),
    .flags  (flags),
    .irq    (irq_pending),
    .uar    (uar)
  );

  mc_cmd_decode u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .ops   (word.ops),
    .cmd   (ucmd)
  );

  assign upc = uar;

  AST_FETCH_START: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == FETCH_ENTRY) |=> (upc == FETCH_ENTRY + ADDR_W'(1))); // R4
  AST_INT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == INT_LAST) |=> (upc == FETCH_ENTRY)); // R8

endmodule

// File: tb/test_mc_ctrl.sv
`timescale 1ns/1ps
module test_mc_ctrl;

  localparam int S_PC = 1, S_MDR = 2, S_ACC = 3, S_IRA = 4, S_ALU = 5, S_SP = 6;
  localparam int D_MAR = 1, D_IR = 2, D_ACC = 3, D_PC = 4, D_TMP = 5, D_MDR = 6;
  localparam int A_ADD = 1, A_SUB = 2;
  localparam int M_RD = 1, M_WR = 2, M_PCI = 3, M_FLG = 4, M_ACK = 5, M_SPD = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  opcode;
  logic [3:0]  flags;
  logic        irq_pending;
  logic [27:0] ucmd;
  logic [5:0]  upc;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  mc_ctrl i_mc_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .opcode      (opcode),
    .flags       (flags),
    .irq_pending (irq_pending),
    .ucmd        (ucmd),
    .upc         (upc)
  );

  function automatic logic [27:0] cv(int s, int d, int a, int m);
    logic [27:0] v;
    v = '0;
    if (s > 0) v[s-1]    = 1'b1;
    if (d > 0) v[7+d-1]  = 1'b1;
    if (a > 0) v[14+a-1] = 1'b1;
    if (m > 0) v[21+m-1] = 1'b1;
    return v;
  endfunction

  task automatic chk(string tag, int eu, logic [27:0] ec);
    checks++;
    if (upc !== 6'(eu) || ucmd !== ec) begin
      errors++;
      $display("FAIL %s: upc=%0d ucmd=%h expected upc=%0d ucmd=%h",
               tag, upc, ucmd, eu, ec);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_fetch(int opc);
    opcode = 3'(opc);
    step; chk("R3 R4 fetch word0", 1, cv(S_PC, D_MAR, 0, 0));
    step; chk("R4 fetch word1", 2, cv(0, 0, 0, M_RD));
    step; chk("R2 R4 fetch word2", 3, cv(S_MDR, D_IR, 0, M_PCI));
    step; chk("R5 dispatch", 8 + 4*opc, '0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; opcode = '0; flags = '0; irq_pending = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset held", 0, '0);
    rst_n = 1'b1;
    chk("R1 reset released", 0, '0);
  endtask

  task automatic t_nop;
    do_fetch(0);
    step; chk("R7 R11 nop return", 0, '0);
  endtask

  task automatic t_load;
    do_fetch(1);
    opcode = 3'd5; irq_pending = 1'b1;
    step; chk("R9 R10 R11 load word0", 13, cv(S_IRA, D_MAR, 0, 0));
    step; chk("R9 R11 load word1", 14, cv(0, 0, 0, M_RD));
    irq_pending = 1'b0;
    step; chk("R10 R11 load word2", 0, cv(S_MDR, D_ACC, 0, 0));
    opcode = 3'd0;
  endtask

  task automatic t_store;
    do_fetch(2);
    step; chk("R11 store word0", 17, cv(S_IRA, D_MAR, 0, 0));
    step; chk("R11 store word1", 18, cv(S_ACC, D_MDR, 0, 0));
    step; chk("R11 store word2", 0, cv(0, 0, 0, M_WR));
  endtask

  task automatic t_add;
    do_fetch(3);
    step; chk("R11 add word0", 21, cv(S_IRA, D_MAR, 0, 0));
    step; chk("R11 add word1", 22, cv(0, 0, 0, M_RD));
    step; chk("R11 add word2", 23, cv(S_MDR, D_TMP, 0, 0));
    step; chk("R2 R11 add all fields", 0, cv(S_ALU, D_ACC, A_ADD, M_FLG));
  endtask

  task automatic t_sub_irq;
    do_fetch(4);
    step; chk("R11 sub word0", 25, cv(S_IRA, D_MAR, 0, 0));
    step; chk("R11 sub word1", 26, cv(0, 0, 0, M_RD));
    step; chk("R11 sub word2", 27, cv(S_MDR, D_TMP, 0, 0));
    irq_pending = 1'b1;
    step; chk("R7 return to interrupt", 4, cv(S_ALU, D_ACC, A_SUB, M_FLG));
    step; chk("R8 int word0", 5, cv(S_SP, D_MAR, 0, M_SPD));
    step; chk("R8 int word1", 6, cv(S_PC, D_MDR, 0, 0));
    step; chk("R8 int word2", 7, cv(0, 0, 0, M_WR));
    step; chk("R8 int exit ignores irq", 0, cv(0, 0, 0, M_ACK));
    irq_pending = 1'b0;
  endtask

  task automatic t_jmp;
    do_fetch(5);
    step; chk("R11 jmp", 0, cv(S_IRA, D_PC, 0, 0));
  endtask

  task automatic t_branch(int opc, logic [3:0] fl, bit taken, string tag);
    int base;
    base = 8 + 4*opc;
    do_fetch(opc);
    flags = fl;
    step; chk(tag, taken ? base + 2 : base + 1, '0);
    flags = ~fl;
    step; chk(tag, 0, taken ? cv(S_IRA, D_PC, 0, 0) : '0);
    flags = '0;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset;
    t_nop;
    t_load;
    t_store;
    t_add;
    t_sub_irq;
    t_jmp;
    t_branch(6, 4'b0001, 1'b1, "R6 negative taken");
    t_branch(6, 4'b1110, 1'b0, "R6 negative not taken");
    t_branch(7, 4'b0010, 1'b1, "R6 zero taken");
    t_branch(7, 4'b1101, 1'b0, "R6 zero not taken");
    t_nop;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule